// File: doc/BRIEF.md
# Banked Prediction Request Router

This block sits between a wide fetch stage and a value-prediction table split into independent banks. Each cycle it may receive a group of up to eight instruction addresses that were fetched together as one trace, with a per-slot valid bit. It decides which bank each address belongs to and resolves bank contention so that every bank sees at most one lookup. Slots whose hint says they are not prediction candidates do not take part.

Two kinds of contention are handled differently. Different addresses that land on the same bank are arbitrated by trace order: the earliest slot wins and the others are refused. Repeated copies of one address, as produced when several loop iterations sit in one trace, share the single lookup made by their first copy. For every slot the router reports its bank, its outcome and an occurrence number. A later distributor uses these to hand the bank results back to every slot, for example to scale a stride by the occurrence number. All decisions are combinational over the group and registered once at the output.

Top module: `pred_req_router`

## Requirements
- R1: For every valid slot of an accepted group, `slot_bank` reports the address modulo the bank count, which is the low three address bits. For an invalid slot, `slot_bank` is 0.
- R2: When candidate slots with different request keys map to one bank, only the lowest-numbered of them is granted (status 01). Every other one is denied (status 10), including later copies of a denied key.
- R3: Candidate slots whose address and table select both equal those of a bank's granted slot are merged (status 11). Only the granted slot produces a bank request.
- R4: `slot_midx` gives the occurrence number of a slot's key among candidate slots in trace order: 0 for granted slots, 1 for the first merged copy, 2 for the next, and so on. It is 0 for idle and denied slots.
- R5: A valid slot with its no-predict hint set reports status 00 (idle). It takes no part in arbitration, so a later candidate on the same bank is granted.
- R6: The table select bit (0 last-value, 1 stride) travels with the bank request. The same address with a different table select is a different key and is arbitrated as such.
- R7: Slots with the valid bit low, and whole cycles with `in_valid` low, are ignored. Their status is idle, and no bank request results from them.
- R8: Results appear on the clock edge after the inputs are sampled, with `out_valid` mirroring `in_valid`. Reset clears every output to zero.
- R9: For each granted bank, `bank_req` is set and `bank_addr`, `bank_tsel` and `bank_src` carry the address, table select and slot index of the granted slot. Banks without a request show zeros.
- R10: At most one slot is granted per bank per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A trace group is presented this cycle |
| slot_valid | input | 8 | Per-slot valid bit |
| slot_skip | input | 8 | Per-slot no-predict hint |
| slot_tsel | input | 8 | Per-slot table select, 0 last-value, 1 stride |
| slot_addr | input | 8x32 | Per-slot instruction address |
| out_valid | output | 1 | Registered results are for a group |
| bank_req | output | 8 | Per-bank lookup request |
| bank_addr | output | 8x32 | Address sent to each bank |
| bank_tsel | output | 8 | Table select sent to each bank |
| bank_src | output | 8x3 | Slot that owns each bank's request |
| slot_bank | output | 8x3 | Bank of each slot |
| slot_status | output | 8x2 | 00 idle, 01 granted, 10 denied, 11 merged |
| slot_midx | output | 8x3 | Occurrence number of the slot's key |

## Verification
Because there is one register stage and no state is carried between groups, a wrong decision shows on the very next edge. It cannot be hidden by later traffic. A mistaken leader search appears as two grants on one bank or as a denied slot that should have won. A faulty key comparison turns merges into denials or the reverse. A miscounted occurrence shows directly on `slot_midx` for the third and later copies. The bench checks each group's full per-slot and per-bank picture in the following cycle, using directed loops, conflicts and hint cases as well as random groups drawn from a small, clash-prone address pool.

// File: rtl/prr_pkg.sv
package prr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_GRANT = 2'b01,
    ST_DENY  = 2'b10,
    ST_MERGE = 2'b11
  } slot_status_e;
endpackage

// File: rtl/prr_bank_sel.sv
module prr_bank_sel #(
  parameter int ADDR_W  = 32,
  parameter int N_BANKS = 8,
  localparam int BANK_W = $clog2(N_BANKS)
) (
  input  logic [ADDR_W-1:0]        addr,
  output logic [BANK_W-1:0]        bank,
  output logic [ADDR_W-BANK_W-1:0] line_tag
);
  // bank count is a power of two: modulo is the low bits
  function automatic logic [BANK_W-1:0] bank_of(input logic [ADDR_W-1:0] a);
    return a[BANK_W-1:0];
  endfunction

  function automatic logic [ADDR_W-BANK_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:BANK_W];
  endfunction

  assign bank     = bank_of(addr);
  assign line_tag = tag_of(addr);
endmodule

// File: rtl/prr_resolve.sv
module prr_resolve
  import prr_pkg::*;
#(
  parameter int N_SLOTS = 8,
  parameter int ADDR_W  = 32,
  parameter int N_BANKS = 8,
  localparam int BANK_W = $clog2(N_BANKS),
  localparam int IDX_W  = $clog2(N_SLOTS),
  localparam int TAG_W  = ADDR_W - BANK_W
) (
  input  logic [N_SLOTS-1:0]             part,
  input  logic [N_SLOTS-1:0][BANK_W-1:0] bank,
  input  logic [N_SLOTS-1:0][TAG_W-1:0]  tag,
  input  logic [N_SLOTS-1:0]             tsel,
  output logic [N_SLOTS-1:0][1:0]        status,
  output logic [N_SLOTS-1:0][IDX_W-1:0]  midx,
  output logic [N_SLOTS-1:0]             grant_vec
);
  // key equality beyond the bank field (bank compared separately)
  function automatic logic key_eq(input logic [TAG_W-1:0] ta, input logic sa,
                                  input logic [TAG_W-1:0] tb, input logic sb);
    return (ta == tb) && (sa == sb);
  endfunction

  logic [N_SLOTS-1:0]            earlier_hit;
  logic [N_SLOTS-1:0][IDX_W-1:0] lead_idx;
  logic [N_SLOTS-1:0][IDX_W-1:0] copy_cnt;
  logic [N_SLOTS-1:0]            same_as_lead;

  genvar i;
  generate
    for (i = 0; i < N_SLOTS; i++) begin : g_slot
      // earliest candidate before slot i on the same bank
      always_comb begin
        earlier_hit[i] = 1'b0;
        lead_idx[i]    = IDX_W'(i);
        for (int j = N_SLOTS - 1; j >= 0; j--) begin
          if (j < i && part[j] && bank[j] == bank[i]) begin
            earlier_hit[i] = 1'b1;
            lead_idx[i]    = IDX_W'(j);
          end
        end
      end

      // number of earlier candidates carrying the same key
      always_comb begin
        copy_cnt[i] = '0;
        for (int j = 0; j < N_SLOTS; j++) begin
          if (j < i && part[j] && bank[j] == bank[i] &&
              key_eq(tag[j], tsel[j], tag[i], tsel[i]))
            copy_cnt[i] = copy_cnt[i] + IDX_W'(1);
        end
      end

      assign same_as_lead[i] = key_eq(tag[lead_idx[i]], tsel[lead_idx[i]],
                                      tag[i], tsel[i]);

      always_comb begin
        if (!part[i]) begin
          status[i] = ST_IDLE;
          midx[i]   = '0;
        end else if (!earlier_hit[i]) begin
          status[i] = ST_GRANT;
          midx[i]   = '0;
        end else if (same_as_lead[i]) begin
          status[i] = ST_MERGE;
          midx[i]   = copy_cnt[i];
        end else begin
          status[i] = ST_DENY;
          midx[i]   = '0;
        end
      end

      assign grant_vec[i] = part[i] && !earlier_hit[i];
    end
  endgenerate
endmodule

// File: rtl/prr_bank_side.sv
module prr_bank_side #(
  parameter int N_SLOTS = 8,
  parameter int ADDR_W  = 32,
  parameter int N_BANKS = 8,
  localparam int BANK_W = $clog2(N_BANKS),
  localparam int IDX_W  = $clog2(N_SLOTS)
) (
  input  logic [N_SLOTS-1:0]              grant_vec,
  input  logic [N_SLOTS-1:0][BANK_W-1:0]  bank,
  input  logic [N_SLOTS-1:0][ADDR_W-1:0]  addr,
  input  logic [N_SLOTS-1:0]              tsel,
  output logic [N_BANKS-1:0]              req,
  output logic [N_BANKS-1:0][ADDR_W-1:0]  baddr,
  output logic [N_BANKS-1:0]              btsel,
  output logic [N_BANKS-1:0][IDX_W-1:0]   bsrc
);
  genvar b;
  generate
    for (b = 0; b < N_BANKS; b++) begin : g_bank
      always_comb begin
        req[b]   = 1'b0;
        baddr[b] = '0;
        btsel[b] = 1'b0;
        bsrc[b]  = '0;
        for (int s = 0; s < N_SLOTS; s++) begin
          if (grant_vec[s] && bank[s] == BANK_W'(b)) begin
            req[b]   = 1'b1;
            baddr[b] = addr[s];
            btsel[b] = tsel[s];
            bsrc[b]  = IDX_W'(s);
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/pred_req_router.sv
module pred_req_router #(
  parameter int N_SLOTS = 8,
  parameter int N_BANKS = 8,
  parameter int ADDR_W  = 32,
  localparam int BANK_W = $clog2(N_BANKS),
  localparam int IDX_W  = $clog2(N_SLOTS),
  localparam int TAG_W  = ADDR_W - BANK_W
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             in_valid,
  input  logic [N_SLOTS-1:0]               slot_valid,
  input  logic [N_SLOTS-1:0]               slot_skip,
  input  logic [N_SLOTS-1:0]               slot_tsel,
  input  logic [N_SLOTS-1:0][ADDR_W-1:0]   slot_addr,
  output logic                             out_valid,
  output logic [N_BANKS-1:0]               bank_req,
  output logic [N_BANKS-1:0][ADDR_W-1:0]   bank_addr,
  output logic [N_BANKS-1:0]               bank_tsel,
  output logic [N_BANKS-1:0][IDX_W-1:0]    bank_src,
  output logic [N_SLOTS-1:0][BANK_W-1:0]   slot_bank,
  output logic [N_SLOTS-1:0][1:0]          slot_status,
  output logic [N_SLOTS-1:0][IDX_W-1:0]    slot_midx
);
  logic [N_SLOTS-1:0]              live_vec;
  logic [N_SLOTS-1:0]              part_vec;
  logic [N_SLOTS-1:0][BANK_W-1:0]  bank_c;
  logic [N_SLOTS-1:0][TAG_W-1:0]   tag_c;
  logic [N_SLOTS-1:0][1:0]         status_c;
  logic [N_SLOTS-1:0][IDX_W-1:0]   midx_c;
  logic [N_SLOTS-1:0]              grant_vec;
  logic [N_BANKS-1:0]              req_c;
  logic [N_BANKS-1:0][ADDR_W-1:0]  baddr_c;
  logic [N_BANKS-1:0]              btsel_c;
  logic [N_BANKS-1:0][IDX_W-1:0]   bsrc_c;
  logic [N_SLOTS-1:0][BANK_W-1:0]  sbank_c;

  assign live_vec = {N_SLOTS{in_valid}} & slot_valid;
  assign part_vec = live_vec & ~slot_skip;

  genvar i;
  generate
    for (i = 0; i < N_SLOTS; i++) begin : g_sel
      prr_bank_sel #(.ADDR_W(ADDR_W), .N_BANKS(N_BANKS)) u_sel (
        .addr     (slot_addr[i]),
        .bank     (bank_c[i]),
        .line_tag (tag_c[i])
      );
      assign sbank_c[i] = live_vec[i] ? bank_c[i] : '0;
    end
  endgenerate

  prr_resolve #(.N_SLOTS(N_SLOTS), .ADDR_W(ADDR_W), .N_BANKS(N_BANKS)) u_resolve (
    .part      (part_vec),
    .bank      (bank_c),
    .tag       (tag_c),
    .tsel      (slot_tsel),
    .status    (status_c),
    .midx      (midx_c),
    .grant_vec (grant_vec)
  );

  prr_bank_side #(.N_SLOTS(N_SLOTS), .ADDR_W(ADDR_W), .N_BANKS(N_BANKS)) u_banks (
    .grant_vec (grant_vec),
    .bank      (bank_c),
    .addr      (slot_addr),
    .tsel      (slot_tsel),
    .req       (req_c),
    .baddr     (baddr_c),
    .btsel     (btsel_c),
    .bsrc      (bsrc_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      bank_req    <= '0;
      bank_addr   <= '0;
      bank_tsel   <= '0;
      bank_src    <= '0;
      slot_bank   <= '0;
      slot_status <= '0;
      slot_midx   <= '0;
    end else begin
      out_valid   <= in_valid;
      bank_req    <= req_c;
      bank_addr   <= baddr_c;
      bank_tsel   <= btsel_c;
      bank_src    <= bsrc_c;
      slot_bank   <= sbank_c;
      slot_status <= status_c;
      slot_midx   <= midx_c;
    end
  end
endmodule

// File: rtl/prr_checker.sv
module prr_checker #(
  parameter int N_SLOTS = 8,
  parameter int N_BANKS = 8,
  localparam int BANK_W = $clog2(N_BANKS),
  localparam int IDX_W  = $clog2(N_SLOTS)
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           in_valid,
  input logic [N_SLOTS-1:0]             slot_valid,
  input logic [N_SLOTS-1:0]             slot_skip,
  input logic                           out_valid,
  input logic [N_BANKS-1:0]             bank_req,
  input logic [N_BANKS-1:0][IDX_W-1:0]  bank_src,
  input logic [N_SLOTS-1:0][BANK_W-1:0] slot_bank,
  input logic [N_SLOTS-1:0][1:0]        slot_status,
  input logic [N_SLOTS-1:0][IDX_W-1:0]  slot_midx
);
  // R8: one registered stage between sample and result
  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R7: no requests without a group
  assert_no_req_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (bank_req == '0));

  genvar b;
  generate
    for (b = 0; b < N_BANKS; b++) begin : g_bchk
      logic [N_SLOTS-1:0] granted_here;
      always_comb begin
        for (int s = 0; s < N_SLOTS; s++)
          granted_here[s] = (slot_status[s] == 2'b01) && (slot_bank[s] == BANK_W'(b));
      end
      // R10: one grant per bank
      assert_one_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(granted_here) <= 1);
      // R9: request owner is a granted slot of this bank
      assert_owner_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bank_req[b] |-> (slot_status[bank_src[b]] == 2'b01 &&
                         slot_bank[bank_src[b]] == BANK_W'(b)));
    end
  endgenerate

  genvar s;
  generate
    for (s = 0; s < N_SLOTS; s++) begin : g_schk
      // R5: hinted slot is idle next cycle
      assert_skip_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && slot_valid[s] && slot_skip[s]) |=> (slot_status[s] == 2'b00));
      // R7: invalid slot is idle next cycle
      assert_invalid_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid || !slot_valid[s]) |=> (slot_status[s] == 2'b00));
      // R4: merged copies carry a nonzero occurrence number, grants carry zero
      assert_merge_idx_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_status[s] == 2'b11) |-> (slot_midx[s] != '0));
      assert_grant_idx_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_status[s] == 2'b01) |-> (slot_midx[s] == '0));
      // R2 and R3: denied or merged slots sit on a bank that has a request
      assert_deny_bank_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_status[s] == 2'b10) |-> bank_req[slot_bank[s]]);
      assert_merge_bank_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_status[s] == 2'b11) |-> bank_req[slot_bank[s]]);
    end
  endgenerate
endmodule

bind pred_req_router prr_checker #(.N_SLOTS(N_SLOTS), .N_BANKS(N_BANKS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .slot_valid  (slot_valid),
  .slot_skip   (slot_skip),
  .out_valid   (out_valid),
  .bank_req    (bank_req),
  .bank_src    (bank_src),
  .slot_bank   (slot_bank),
  .slot_status (slot_status),
  .slot_midx   (slot_midx)
);

// File: tb/tb_pred_req_router.sv
module tb_pred_req_router;
  localparam int NS = 8;
  localparam int NB = 8;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic                    in_valid = 1'b0;
  logic [NS-1:0]           slot_valid = '0, slot_skip = '0, slot_tsel = '0;
  logic [NS-1:0][AW-1:0]   slot_addr = '0;
  logic                    out_valid;
  logic [NB-1:0]           bank_req, bank_tsel;
  logic [NB-1:0][AW-1:0]   bank_addr;
  logic [NB-1:0][2:0]      bank_src;
  logic [NS-1:0][2:0]      slot_bank, slot_midx;
  logic [NS-1:0][1:0]      slot_status;

  pred_req_router dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .slot_valid(slot_valid),
    .slot_skip(slot_skip), .slot_tsel(slot_tsel), .slot_addr(slot_addr),
    .out_valid(out_valid), .bank_req(bank_req), .bank_addr(bank_addr),
    .bank_tsel(bank_tsel), .bank_src(bank_src), .slot_bank(slot_bank),
    .slot_status(slot_status), .slot_midx(slot_midx)
  );

  typedef struct {
    logic                  ov;
    logic [NB-1:0]         req;
    logic [NB-1:0][AW-1:0] baddr;
    logic [NB-1:0]         btsel;
    logic [NB-1:0][2:0]    bsrc;
    logic [NS-1:0][2:0]    sbank;
    logic [NS-1:0][1:0]    sst;
    logic [NS-1:0][2:0]    smidx;
    string                 tag;
  } exp_t;

  exp_t exp_q[$];
  int n_run = 0;
  int n_fail = 0;

  // Bank-by-bank model: scan slots in order, the first candidate owns the bank,
  // later same-key copies are numbered, anything else is refused.
  function automatic exp_t model(input logic iv, input logic [NS-1:0] v, sk, ts,
                                 input logic [NS-1:0][AW-1:0] a, input string tag);
    exp_t e;
    e.ov = iv; e.req = '0; e.baddr = '0; e.btsel = '0; e.bsrc = '0;
    e.sbank = '0; e.sst = '0; e.smidx = '0; e.tag = tag;
    if (!iv) return e;
    for (int s = 0; s < NS; s++) if (v[s]) e.sbank[s] = 3'(a[s] % NB);
    for (int b = 0; b < NB; b++) begin
      int owner = -1;
      int seen = 0;
      for (int s = 0; s < NS; s++) begin
        if (v[s] && !sk[s] && (a[s] % NB) == b) begin
          if (owner < 0) begin
            owner = s;
            e.sst[s] = 2'b01;
            e.req[b] = 1'b1; e.baddr[b] = a[s]; e.btsel[b] = ts[s]; e.bsrc[b] = 3'(s);
          end else if (a[s] == a[owner] && ts[s] == ts[owner]) begin
            seen++;
            e.sst[s] = 2'b11;
            e.smidx[s] = 3'(seen);
          end else begin
            e.sst[s] = 2'b10;
          end
        end
      end
    end
    return e;
  endfunction

  task automatic send(input logic iv, input logic [NS-1:0] v, sk, ts,
                      input logic [NS-1:0][AW-1:0] a, input string tag);
    @(negedge clk);
    in_valid = iv; slot_valid = v; slot_skip = sk; slot_tsel = ts; slot_addr = a;
    exp_q.push_back(model(iv, v, sk, ts, a, tag));
  endtask

  // monitor: results of the group driven at the previous negedge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        bit bad;
        e = exp_q.pop_front();
        bad = 0;
        n_run++;
        if (out_valid !== e.ov) begin
          bad = 1; $display("FAIL %s out_valid act=%0b exp=%0b", e.tag, out_valid, e.ov);
        end
        if (bank_req !== e.req) begin
          bad = 1; $display("FAIL %s bank_req act=%b exp=%b", e.tag, bank_req, e.req);
        end
        if (bank_addr !== e.baddr || bank_tsel !== e.btsel || bank_src !== e.bsrc) begin
          bad = 1;
          $display("FAIL %s bank side act=%h/%b/%h exp=%h/%b/%h", e.tag,
                   bank_addr, bank_tsel, bank_src, e.baddr, e.btsel, e.bsrc);
        end
        if (slot_bank !== e.sbank) begin
          bad = 1; $display("FAIL %s slot_bank act=%h exp=%h", e.tag, slot_bank, e.sbank);
        end
        if (slot_status !== e.sst) begin
          bad = 1; $display("FAIL %s slot_status act=%b exp=%b", e.tag, slot_status, e.sst);
        end
        if (slot_midx !== e.smidx) begin
          bad = 1; $display("FAIL %s slot_midx act=%h exp=%h", e.tag, slot_midx, e.smidx);
        end
        if (bad) n_fail++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  logic [NS-1:0][AW-1:0] a;

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R8: reset clears outputs
    n_run++;
    if (out_valid !== 1'b0 || bank_req !== '0 || slot_status !== '0 ||
        slot_bank !== '0 || slot_midx !== '0 || bank_addr !== '0) begin
      n_fail++;
      $display("FAIL R8 reset outputs act=%b/%b exp=0/0", out_valid, bank_req);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R1, R9: eight addresses on eight different banks
    for (int s = 0; s < NS; s++) a[s] = 32'h1000 + 32'(s) * 9;
    send(1, 8'hFF, 8'h00, 8'hA5, a, "R1_R9_distinct");

    // R2: two different addresses on bank 3, slot 1 before slot 5
    for (int s = 0; s < NS; s++) a[s] = 32'h2000 + 32'(s);
    a[1] = 32'h2003; a[5] = 32'h20B3; a[3] = 32'h2204;
    send(1, 8'hFF, 8'h00, 8'h00, a, "R2_conflict");

    // R3, R4: three loop copies of one address plus neighbours
    a = '0;
    a[0] = 32'h400A; a[1] = 32'h4011; a[2] = 32'h400A; a[3] = 32'h4013;
    a[4] = 32'h400A; a[5] = 32'h4015; a[6] = 32'h4016; a[7] = 32'h4017;
    send(1, 8'hFF, 8'h00, 8'h15, a, "R3_R4_loop3");

    // R4: all eight slots the same address, occurrence numbers 0..7
    for (int s = 0; s < NS; s++) a[s] = 32'h5556;
    send(1, 8'hFF, 8'h00, 8'hFF, a, "R4_all_copies");

    // R5: hinted earliest slot gives way to a later one on the same bank
    for (int s = 0; s < NS; s++) a[s] = 32'h6000 + 32'(s) * 8;
    send(1, 8'hFF, 8'h01, 8'h00, a, "R5_skip_first");
    send(1, 8'hFF, 8'hFF, 8'h00, a, "R5_skip_all");

    // R6: same address, different table select; then same select merges
    for (int s = 0; s < NS; s++) a[s] = 32'h7001;
    send(1, 8'h0F, 8'h00, 8'h0A, a, "R6_tsel_split");

    // R2: copy of a refused key stays refused
    a = '0;
    a[0] = 32'h8000; a[1] = 32'h8008; a[2] = 32'h8008; a[3] = 32'h8000;
    send(1, 8'h0F, 8'h00, 8'h00, a, "R2_refused_copy");

    // R7: invalid slots and a cycle without a group
    for (int s = 0; s < NS; s++) a[s] = 32'h9002;
    send(1, 8'b1010_0100, 8'h00, 8'h00, a, "R7_sparse");
    send(0, 8'hFF, 8'h00, 8'h00, a, "R7_no_group");
    send(1, 8'h00, 8'h00, 8'h00, a, "R7_all_invalid");

    // R8, R10: back-to-back random groups from a clash-prone pool
    for (int n = 0; n < 300; n++) begin
      for (int s = 0; s < NS; s++)
        a[s] = 32'h100 + 32'($urandom % 4) * 8 + 32'($urandom % 3);
      send(($urandom % 8) != 0, 8'($urandom), 8'($urandom % 4 == 0 ? $urandom : 0),
           8'($urandom % 2 == 0 ? 0 : $urandom), a, "R10_random");
    end
    send(0, 8'h00, 8'h00, 8'h00, a, "R8_drain");

    while (exp_q.size() > 0) @(posedge clk);
    @(posedge clk);
    #3;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule